// File: doc/BRIEF.md
# Fractional Divisor Baud Generator

This block produces the 16x oversampling tick that a serial port's transmitter and receiver share. The tick period, counted in system clock cycles, is a 16-bit integer divisor plus a fraction in sixteenths. The fraction is realised by a 4-bit phase accumulator. Each time the tick fires, the fraction is added to the accumulator. Whenever that addition carries, the following period is one clock longer. Over sixteen periods the average therefore comes out at divisor + fraction/16.

A host reaches the block through a small address/data register port. Writes take effect on the clock edge, and reads are combinational. A line control register always sits at address 3. Its top bit, the divisor access bit, decides what addresses 0 to 2 reach. When the bit is set, they reach the divisor low byte, the divisor high byte and the fraction register. When it is clear, addresses 0 and 1 reach a holding-data byte and an interrupt-enable byte, and address 2 is locked.

The upper nibble of the fraction register does not affect the tick. It carries four mode flags that are kept here for neighbouring blocks.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset every register reads zero, all mode flags are low and tick is low.
- R2: The line control register at address 3 can be written and read whatever the value of its bit 7.
- R3: With line control bit 7 set, addresses 0, 1 and 2 write and read the divisor low byte, the divisor high byte and the fraction register.
- R4: With line control bit 7 clear, addresses 0 and 1 write and read the holding-data and interrupt-enable registers (hold_o, ier_o) and leave the divisor untouched. Address 2 then reads 0x00, and writes to it are ignored.
- R5: With fraction 0 and divisor D of 2 or more, tick is a one-cycle pulse that repeats every D cycles. With D = 1, tick is high on every cycle.
- R6: With fraction F (bits 3:0 of the fraction register), the tick adds F to a 4-bit accumulator that starts at 0. A carry makes the next period D+1 cycles long. Any 16 consecutive periods after the first therefore span 16·D+F cycles.
- R7: A divisor of zero holds tick low.
- R8: A write to any divisor register (addresses 0 to 2 while bit 7 is set) restarts the count and clears the accumulator. The first tick then comes D cycles after the write edge, with tick high in the D-th cycle after that edge, counting the cycle that begins at the edge as the first. This holds even when the write lands in a tick cycle.
- R9: Fraction register bits 7, 6, 5 and 4 drive rs485_pol, multidrop, xon_par_chk and fast_ir.
- R10: bus_rdata shows the addressed register in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tick | output | 1 | 16x oversampling tick |
| lcr_o | output | 8 | Line control register contents |
| hold_o | output | 8 | Holding-data register contents |
| ier_o | output | 8 | Interrupt-enable register contents |
| rs485_pol | output | 1 | Direction-pin polarity flag |
| multidrop | output | 1 | Multi-drop enable flag |
| xon_par_chk | output | 1 | Flow-control parity-check flag |
| fast_ir | output | 1 | Quarter-bit infrared pulse flag |

## Verification
Two events can fall in the same cycle: a divisor write that restarts the count, and a tick that would otherwise reload the count and advance the accumulator. The bench forces this collision. It watches tick just after a rising edge and, in the same cycle, drives a divisor write, so the write and the tick share the next edge. A behavioural countdown model in the bench lets the restart win: it drops the pending carry and starts a full new period. The model is compared with tick and every register output on each clock.

// File: rtl/baud_frac_gen.sv
module baud_frac_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tick,
  output logic [7:0] lcr_o,
  output logic [7:0] hold_o,
  output logic [7:0] ier_o,
  output logic       rs485_pol,
  output logic       multidrop,
  output logic       xon_par_chk,
  output logic       fast_ir
);
  localparam logic [1:0] A_LO  = 2'd0;
  localparam logic [1:0] A_HI  = 2'd1;
  localparam logic [1:0] A_FX  = 2'd2;
  localparam logic [1:0] A_LCR = 2'd3;

  logic [7:0]  lcr_q, hold_q, ier_q, dlo_q, dhi_q, dfx_q;
  logic [15:0] cnt_q;
  logic [3:0]  acc_q;
  logic        ext_q;

  logic        dlab;
  logic [15:0] div;
  logic        div_wr;
  logic [16:0] limit;
  logic [4:0]  sum;

  assign dlab   = lcr_q[7];
  assign div    = {dhi_q, dlo_q};
  assign div_wr = bus_wr && dlab && (bus_addr != A_LCR);
  assign limit  = {1'b0, div} - 17'd1 + {16'd0, ext_q};
  assign sum    = {1'b0, acc_q} + {1'b0, dfx_q[3:0]};
  assign tick   = (div != 16'd0) && ({1'b0, cnt_q} == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      hold_q <= '0;
      ier_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      dfx_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_LO:    if (dlab) dlo_q <= bus_wdata; else hold_q <= bus_wdata;
        A_HI:    if (dlab) dhi_q <= bus_wdata; else ier_q  <= bus_wdata;
        A_FX:    if (dlab) dfx_q <= bus_wdata;
        default: lcr_q <= bus_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (div_wr) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      acc_q <= sum[3:0];
      ext_q <= sum[4];
    end else if (div != 16'd0) begin
      cnt_q <= cnt_q + 16'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO:    bus_rdata = dlab ? dlo_q : hold_q;
      A_HI:    bus_rdata = dlab ? dhi_q : ier_q;
      A_FX:    bus_rdata = dlab ? dfx_q : 8'h00;
      default: bus_rdata = lcr_q;
    endcase
  end

  assign lcr_o       = lcr_q;
  assign hold_o      = hold_q;
  assign ier_o       = ier_q;
  assign rs485_pol   = dfx_q[7];
  assign multidrop   = dfx_q[6];
  assign xon_par_chk = dfx_q[5];
  assign fast_ir     = dfx_q[4];
endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic        tick,
  input logic [7:0]  lcr,
  input logic [15:0] div,
  input logic [7:0]  frac,
  input logic [15:0] cnt,
  input logic [3:0]  flags
);
  logic dwr;
  assign dwr = bus_wr && lcr[7] && (bus_addr != 2'd3);

  p_lcr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> lcr == $past(bus_wdata));

  p_frac_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !lcr[7]) |=> $stable(frac));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 16'd1 && !dwr) |=> !tick);

  p_period_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div != 16'd0) |-> cnt <= div);

  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div == 16'd0) |-> !tick);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dwr |=> cnt == 16'd0);

  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && lcr[7]) |=> flags == $past(bus_wdata[7:4]));
endmodule

bind baud_frac_gen baud_frac_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .tick(tick), .lcr(lcr_q), .div(div),
  .frac(dfx_q), .cnt(cnt_q),
  .flags({rs485_pol, multidrop, xon_par_chk, fast_ir})
);

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, lcr_o, hold_o, ier_o;
  logic tick, rs485_pol, multidrop, xon_par_chk, fast_ir;

  always #4 clk = ~clk;

  baud_frac_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .lcr_o(lcr_o), .hold_o(hold_o), .ier_o(ier_o), .rs485_pol(rs485_pol),
    .multidrop(multidrop), .xon_par_chk(xon_par_chk), .fast_ir(fast_ir)
  );

  int checks = 0;
  int errors = 0;
  string ph = "R1";
  bit done = 0;

  int m_lcr = 0, m_hold = 0, m_ier = 0, m_lo = 0, m_hi = 0, m_fx = 0;
  int m_left = 0, m_acc = 0;

  function automatic int mdiv();
    return m_hi * 256 + m_lo;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: countdown to the next tick
  always @(posedge clk) begin
    if (rst_n) begin
      int d;
      bit tk, dl, dw;
      d  = mdiv();
      tk = (d != 0) && (m_left == 1);
      dl = (m_lcr >= 128);
      dw = bus_wr && dl && (bus_addr != 2'd3);
      if (bus_wr) begin
        case (bus_addr)
          2'd0: if (dl) m_lo = bus_wdata; else m_hold = bus_wdata;
          2'd1: if (dl) m_hi = bus_wdata; else m_ier = bus_wdata;
          2'd2: if (dl) m_fx = bus_wdata;
          default: m_lcr = bus_wdata;
        endcase
      end
      if (dw) begin
        m_left = mdiv();
        m_acc = 0;
      end else if (tk) begin
        m_acc += m_fx % 16;
        if (m_acc >= 16) begin
          m_acc -= 16;
          m_left = d + 1;
        end else m_left = d;
      end else if (d != 0) m_left--;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int er;
      bit dl;
      dl = (m_lcr >= 128);
      case (bus_addr)
        2'd0: er = dl ? m_lo : m_hold;
        2'd1: er = dl ? m_hi : m_ier;
        2'd2: er = dl ? m_fx : 0;
        default: er = m_lcr;
      endcase
      chk({ph, " tick"}, tick, (mdiv() != 0 && m_left == 1));
      chk("R10 rdata", bus_rdata, er);
      chk("R2 lcr_o", lcr_o, m_lcr);
      chk("R4 hold_o", hold_o, m_hold);
      chk("R4 ier_o", ier_o, m_ier);
      chk("R9 flags", {rs485_pol, multidrop, xon_par_chk, fast_ir}, m_fx / 16);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3;
    chk("R1 tick", tick, 0);
    chk("R1 lcr", lcr_o, 0);
    chk("R1 flags", {rs485_pol, multidrop, xon_par_chk, fast_ir}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(3);
    // R4: dlab clear reaches data/IER, address 2 locked
    ph = "R4";
    wr(2'd0, 8'h5A); wr(2'd1, 8'h0F); wr(2'd2, 8'hFF);
    bus_addr = 2'd2; #1; chk("R4 locked read", bus_rdata, 0);
    chk("R7 no tick", tick, 0);
    // R2 + R3
    ph = "R3";
    wr(2'd3, 8'h83);
    bus_addr = 2'd3; #1; chk("R2 lcr read", bus_rdata, 8'h83);
    wr(2'd1, 8'h00); wr(2'd2, 8'hA0); wr(2'd0, 8'h04);
    bus_addr = 2'd2; #1; chk("R3 frac read", bus_rdata, 8'hA0);
    chk("R9 flags", {rs485_pol, multidrop, xon_par_chk, fast_ir}, 4'b1010);
    chk("R4 hold kept", hold_o, 8'h5A);
    ph = "R5";
    idle(30);
    wr(2'd0, 8'h01); ph = "R5 d1"; idle(6);
    // R6 fraction: D=3, F=5, measure tick 1 to tick 17
    ph = "R6";
    wr(2'd2, 8'h05); wr(2'd0, 8'h03);
    begin
      int n, t;
      n = 0; t = 0;
      while (t < 17) begin
        @(negedge clk);
        if (t > 0) n++;
        if (tick) t++;
      end
      chk("R6 span of 16 periods", n, 16 * 3 + 5);
    end
    @(posedge clk); #1;
    // R8 collision: divisor write in a tick cycle
    ph = "R8";
    wr(2'd2, 8'h0F); wr(2'd0, 8'h04);
    for (int k = 0; k < 3; k++) begin
      while (!tick) begin @(posedge clk); #1; end
      wr(2'd0, 8'h04);
      begin
        int c;
        c = 0;
        do begin @(negedge clk); c++; end while (!tick && c < 50);
        chk("R8 first tick after restart", c, 4);
      end
      @(posedge clk); #1;
    end
    idle(40);
    // R7: zero divisor
    ph = "R7";
    wr(2'd0, 8'h00);
    begin
      int s;
      s = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); s += tick; end
      chk("R7 zero divisor ticks", s, 0);
    end
    @(posedge clk); #1;
    wr(2'd3, 8'h00); wr(2'd0, 8'h77);
    chk("R4 divisor untouched", hold_o, 8'h77);
    wr(2'd3, 8'h80); bus_addr = 2'd0; #1;
    chk("R4 low byte kept", bus_rdata, 0);
    idle(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule